// File: doc/BRIEF.md
# Host Bus and DMA Arbiter

This block sits between a serial-bus terminal controller and a 16-bit memory bus that the controller shares with a host CPU. It couples the controller to memory in one of two ways, chosen by a single mode pin. In pass-through mode the CPU's read, write and memory-select strobes are forwarded to the RAM whenever the controller is not using it. In DMA mode the block raises a bus request, waits for a grant, and only then drives memory strobes.

The block also controls the output enables of the address and data bus drivers. It decodes host accesses to the controller's register file and refuses them while the controller owns memory. It keeps the one register bit that acts on arbitration: a busy flag that, in remote-terminal operation, holds back any new DMA request.

Inside, the controller's memory accesses arrive as a valid/ready stream of beats. Each beat carries an address, write data, a direction and a last-beat flag. A producer holds `xfer_valid` and a stable payload until it sees `xfer_ready` at a clock edge. Ready is the only back-pressure, and it is high only while the block owns memory and, in DMA mode, the grant is present. Read data returns as a one-cycle `rsp_valid` pulse with no ready. The consumer must take it in that cycle.

Top module: `host_dma_arbiter`

## Requirements
- R1: With `mode_dma`=0 and `mem_own` low, `mem_rd`, `mem_wr` and `mem_sel` equal `host_rd`, `host_wr` and `host_memsel` in the same cycle.
- R2: With `mode_dma`=1, no memory strobe is asserted unless `dma_gnt` is high and `mem_own` is high. CPU strobes are never forwarded in this mode.
- R3: `addr_oe` and `data_oe` are low unless `mem_own` is high or both `host_sel` and `host_rd` are high.
- R4: While `mem_own` is high, host register accesses have no effect. `reg_wstb` stays zero, the busy flag keeps its value, and the data bus carries the controller's write data, not register read data.
- R5: `mem_own` is high exactly while the arbiter is in its owning state. That state is entered one cycle after a pending beat is seen in pass-through mode, and one cycle after the grant is sampled in DMA mode. It is left after the last beat is accepted.
- R6: `addr_off` high forces `addr_oe` low.
- R7: `burst` is high while owning if a non-last beat is offered or a non-last beat has already been accepted in the current ownership. It is low outside ownership.
- R8: With `host_sel` and `host_wr` high, register index `host_idx` 0 to 13 gives a one-hot `reg_wstb` with bit `host_idx` set. Indices 14 and 15 give zero. A host read of 0 to 13 drives `reg_rdata` onto `data_out`, and a read of 14 or 15 drives zero.
- R9: A write to register index 3 loads the busy flag from data bit 15. While `rt_mode` and busy are both high, the arbiter stays idle: `dma_req` and `mem_own` stay low.
- R10: `dma_req` rises one cycle after a beat is seen in idle (DMA mode). It stays high through the last accepted beat and falls the cycle after. The arbiter then waits until `dma_gnt` is low before it may raise `dma_req` again.
- R11: `xfer_ready` is high only while owning (and granted, in DMA mode). For an accepted read beat, `rsp_valid` pulses for one cycle in the next cycle, with `rsp_data` equal to `mem_rdata` at acceptance.
- R12: An active-low asynchronous reset drops `mem_own`, `dma_req`, `burst`, `rsp_valid`, `addr_oe`, `data_oe` and the busy flag at once and returns the arbiter to idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_dma | input | 1 | 0 = pass-through coupling, 1 = granted DMA |
| rt_mode | input | 1 | Controller is operating as a remote terminal |
| host_sel | input | 1 | Host chip-select for the register file |
| host_rd | input | 1 | Host read strobe |
| host_wr | input | 1 | Host write strobe |
| host_memsel | input | 1 | Host memory-select strobe |
| host_idx | input | 4 | Low address bits selecting a register |
| host_wdata | input | 16 | Host write data |
| addr_off | input | 1 | Host forces the address drivers off |
| reg_rdata | input | 16 | Read data of the selected register |
| reg_wstb | output | 14 | One-hot register write strobes |
| dma_req | output | 1 | Bus request to the host arbiter |
| dma_gnt | input | 1 | Bus grant from the host arbiter |
| mem_own | output | 1 | Controller owns memory |
| burst | output | 1 | Multi-beat transfer in progress |
| mem_rd | output | 1 | Memory read strobe |
| mem_wr | output | 1 | Memory write strobe |
| mem_sel | output | 1 | Memory select strobe |
| addr_out | output | 16 | Address bus value |
| addr_oe | output | 1 | Address bus driver enable |
| data_out | output | 16 | Data bus value |
| data_oe | output | 1 | Data bus driver enable |
| mem_rdata | input | 16 | Data returned by memory |
| xfer_valid | input | 1 | Beat offered by the controller |
| xfer_ready | output | 1 | Beat accepted at this edge |
| xfer_write | input | 1 | Beat direction, 1 = write |
| xfer_last | input | 1 | Beat is the last of its transfer |
| xfer_addr | input | 16 | Beat address |
| xfer_wdata | input | 16 | Beat write data |
| rsp_valid | output | 1 | Read data valid pulse |
| rsp_data | output | 16 | Read data |

## Verification
The coupling function is exercised with single-beat writes and reads in pass-through mode, which show when ownership starts and when read data returns. A three-beat DMA burst with a delayed grant separates waiting for the grant from owning memory, and shows that `burst` spans every beat. A second transfer is queued while the grant is still held after the burst, to show that no new request is raised until the grant falls. Host register writes and reads during ownership are checked against the same accesses made while idle, so that blocking is told apart from decoding. The busy flag is set with remote-terminal operation turned on and then off, to tell inhibition by busy from inhibition by mode.

// File: rtl/hba_pkg.sv
package hba_pkg;
  typedef enum logic [1:0] {
    ARB_IDLE  = 2'd0,
    ARB_REQ   = 2'd1,
    ARB_OWN   = 2'd2,
    ARB_DRAIN = 2'd3
  } arb_state_t;
endpackage

// File: rtl/hba_reg_decode.sv
module hba_reg_decode #(
  parameter int RA_W     = 4,
  parameter int NUM_REGS = 14,
  parameter int DW       = 16,
  parameter int BUSY_REG = 3,
  parameter int BUSY_BIT = 15
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                host_sel,
  input  logic                host_rd,
  input  logic                host_wr,
  input  logic [RA_W-1:0]     host_idx,
  input  logic [DW-1:0]       host_wdata,
  input  logic [DW-1:0]       reg_rdata,
  input  logic                blocked,
  output logic [NUM_REGS-1:0] reg_wstb,
  output logic                rd_drive,
  output logic [DW-1:0]       rd_data,
  output logic                busy
);
  localparam logic [RA_W:0]   LIMIT    = (RA_W+1)'(NUM_REGS);
  localparam logic [RA_W-1:0] BUSY_IDX = RA_W'(BUSY_REG);

  logic in_range;
  logic wr_ok;

  assign in_range = ({1'b0, host_idx} < LIMIT);
  assign wr_ok    = host_sel & host_wr & ~blocked & in_range;
  assign rd_drive = host_sel & host_rd & ~blocked;
  assign rd_data  = in_range ? reg_rdata : '0;

  for (genvar i = 0; i < NUM_REGS; i++) begin : g_wstb
    assign reg_wstb[i] = wr_ok && (host_idx == RA_W'(i));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      busy <= 1'b0;
    else if (wr_ok && host_idx == BUSY_IDX)
      busy <= host_wdata[BUSY_BIT];
  end
endmodule

// File: rtl/hba_arb_fsm.sv
module hba_arb_fsm
  import hba_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic mode_dma,
  input  logic inhibit,
  input  logic xfer_valid,
  input  logic xfer_last,
  input  logic dma_gnt,
  output logic own,
  output logic dma_req,
  output logic ready,
  output logic fire,
  output logic burst
);
  arb_state_t st_q, st_d;
  logic       mid_q;

  assign own     = (st_q == ARB_OWN);
  assign ready   = own && (!mode_dma || dma_gnt);
  assign fire    = ready && xfer_valid;
  assign dma_req = (st_q == ARB_REQ) || (own && mode_dma);
  assign burst   = own && (mid_q || (xfer_valid && !xfer_last));

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ARB_IDLE:  if (xfer_valid && !inhibit) st_d = mode_dma ? ARB_REQ : ARB_OWN;
      ARB_REQ:   if (dma_gnt) st_d = ARB_OWN;
      ARB_OWN:   if (fire && xfer_last) st_d = mode_dma ? ARB_DRAIN : ARB_IDLE;
      ARB_DRAIN: if (!dma_gnt) st_d = ARB_IDLE;
      default:   st_d = ARB_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ARB_IDLE;
      mid_q <= 1'b0;
    end else begin
      st_q <= st_d;
      if (fire) mid_q <= !xfer_last;
    end
  end
endmodule

// File: rtl/hba_bus_mux.sv
module hba_bus_mux #(
  parameter int AW = 16,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          mode_dma,
  input  logic          own,
  input  logic          fire,
  input  logic          host_rd,
  input  logic          host_wr,
  input  logic          host_memsel,
  input  logic          addr_off,
  input  logic          rd_drive,
  input  logic [DW-1:0] rd_data,
  input  logic          xfer_valid,
  input  logic          xfer_write,
  input  logic [AW-1:0] xfer_addr,
  input  logic [DW-1:0] xfer_wdata,
  input  logic [DW-1:0] mem_rdata,
  output logic          mem_rd,
  output logic          mem_wr,
  output logic          mem_sel,
  output logic [AW-1:0] addr_out,
  output logic          addr_oe,
  output logic [DW-1:0] data_out,
  output logic          data_oe,
  output logic          rsp_valid,
  output logic [DW-1:0] rsp_data
);
  logic fwd;

  assign fwd = !mode_dma && !own;

  always_comb begin
    if (fwd) begin
      mem_rd  = host_rd;
      mem_wr  = host_wr;
      mem_sel = host_memsel;
    end else begin
      mem_rd  = fire && !xfer_write;
      mem_wr  = fire && xfer_write;
      mem_sel = fire;
    end
  end

  assign addr_out = xfer_addr;
  assign addr_oe  = own && !addr_off;
  assign data_out = own ? xfer_wdata : rd_data;
  assign data_oe  = own ? (xfer_valid && xfer_write) : rd_drive;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_data  <= '0;
    end else begin
      rsp_valid <= fire && !xfer_write;
      if (fire && !xfer_write) rsp_data <= mem_rdata;
    end
  end
endmodule

// File: rtl/host_dma_arbiter.sv
module host_dma_arbiter #(
  parameter int AW       = 16,
  parameter int DW       = 16,
  parameter int RA_W     = 4,
  parameter int NUM_REGS = 14,
  parameter int BUSY_REG = 3,
  parameter int BUSY_BIT = 15
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                mode_dma,
  input  logic                rt_mode,
  input  logic                host_sel,
  input  logic                host_rd,
  input  logic                host_wr,
  input  logic                host_memsel,
  input  logic [RA_W-1:0]     host_idx,
  input  logic [DW-1:0]       host_wdata,
  input  logic                addr_off,
  input  logic [DW-1:0]       reg_rdata,
  output logic [NUM_REGS-1:0] reg_wstb,
  output logic                dma_req,
  input  logic                dma_gnt,
  output logic                mem_own,
  output logic                burst,
  output logic                mem_rd,
  output logic                mem_wr,
  output logic                mem_sel,
  output logic [AW-1:0]       addr_out,
  output logic                addr_oe,
  output logic [DW-1:0]       data_out,
  output logic                data_oe,
  input  logic [DW-1:0]       mem_rdata,
  input  logic                xfer_valid,
  output logic                xfer_ready,
  input  logic                xfer_write,
  input  logic                xfer_last,
  input  logic [AW-1:0]       xfer_addr,
  input  logic [DW-1:0]       xfer_wdata,
  output logic                rsp_valid,
  output logic [DW-1:0]       rsp_data
);
  logic          busy_flag;
  logic          rd_drive;
  logic [DW-1:0] rd_data;
  logic          fire;
  logic          inhibit;

  assign inhibit = rt_mode && busy_flag;

  hba_reg_decode #(
    .RA_W(RA_W), .NUM_REGS(NUM_REGS), .DW(DW),
    .BUSY_REG(BUSY_REG), .BUSY_BIT(BUSY_BIT)
  ) u_dec (
    .clk        (clk),
    .rst_n      (rst_n),
    .host_sel   (host_sel),
    .host_rd    (host_rd),
    .host_wr    (host_wr),
    .host_idx   (host_idx),
    .host_wdata (host_wdata),
    .reg_rdata  (reg_rdata),
    .blocked    (mem_own),
    .reg_wstb   (reg_wstb),
    .rd_drive   (rd_drive),
    .rd_data    (rd_data),
    .busy       (busy_flag)
  );

  hba_arb_fsm u_arb (
    .clk        (clk),
    .rst_n      (rst_n),
    .mode_dma   (mode_dma),
    .inhibit    (inhibit),
    .xfer_valid (xfer_valid),
    .xfer_last  (xfer_last),
    .dma_gnt    (dma_gnt),
    .own        (mem_own),
    .dma_req    (dma_req),
    .ready      (xfer_ready),
    .fire       (fire),
    .burst      (burst)
  );

  hba_bus_mux #(.AW(AW), .DW(DW)) u_mux (
    .clk         (clk),
    .rst_n       (rst_n),
    .mode_dma    (mode_dma),
    .own         (mem_own),
    .fire        (fire),
    .host_rd     (host_rd),
    .host_wr     (host_wr),
    .host_memsel (host_memsel),
    .addr_off    (addr_off),
    .rd_drive    (rd_drive),
    .rd_data     (rd_data),
    .xfer_valid  (xfer_valid),
    .xfer_write  (xfer_write),
    .xfer_addr   (xfer_addr),
    .xfer_wdata  (xfer_wdata),
    .mem_rdata   (mem_rdata),
    .mem_rd      (mem_rd),
    .mem_wr      (mem_wr),
    .mem_sel     (mem_sel),
    .addr_out    (addr_out),
    .addr_oe     (addr_oe),
    .data_out    (data_out),
    .data_oe     (data_oe),
    .rsp_valid   (rsp_valid),
    .rsp_data    (rsp_data)
  );
endmodule

// File: rtl/hba_checker.sv
module hba_checker #(
  parameter int NUM_REGS = 14
) (
  input logic                clk,
  input logic                rst_n,
  input logic                mode_dma,
  input logic                rt_mode,
  input logic                busy,
  input logic                host_sel,
  input logic                host_rd,
  input logic                addr_off,
  input logic                dma_gnt,
  input logic                dma_req,
  input logic                mem_own,
  input logic                mem_rd,
  input logic                mem_wr,
  input logic                mem_sel,
  input logic                addr_oe,
  input logic                data_oe,
  input logic                burst,
  input logic [NUM_REGS-1:0] reg_wstb,
  input logic                xfer_valid,
  input logic                xfer_ready,
  input logic                xfer_write,
  input logic                rsp_valid
);
  assert_dma_strobe_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_dma && (mem_rd || mem_wr || mem_sel)) |-> (dma_gnt && mem_own));

  assert_hiz_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_own && !(host_sel && host_rd)) |-> (!addr_oe && !data_oe));

  assert_block_R4: assert property (@(posedge clk) disable iff (!rst_n)
    mem_own |-> (reg_wstb == '0));

  assert_busy_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $past(mem_own) |-> $stable(busy));

  assert_req_own_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_own && mode_dma) |-> dma_req);

  assert_addr_off_R6: assert property (@(posedge clk) disable iff (!rst_n)
    addr_off |-> !addr_oe);

  assert_burst_R7: assert property (@(posedge clk) disable iff (!rst_n)
    burst |-> mem_own);

  assert_onehot_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(reg_wstb));

  assert_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dma_req) |-> !$past(rt_mode && busy));

  assert_regrant_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dma_req) |-> !$past(dma_gnt));

  assert_ready_R11: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_ready |-> mem_own);

  assert_rsp_R11: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> $past(xfer_valid && xfer_ready && !xfer_write));
endmodule

bind host_dma_arbiter hba_checker #(.NUM_REGS(NUM_REGS)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .mode_dma   (mode_dma),
  .rt_mode    (rt_mode),
  .busy       (busy_flag),
  .host_sel   (host_sel),
  .host_rd    (host_rd),
  .addr_off   (addr_off),
  .dma_gnt    (dma_gnt),
  .dma_req    (dma_req),
  .mem_own    (mem_own),
  .mem_rd     (mem_rd),
  .mem_wr     (mem_wr),
  .mem_sel    (mem_sel),
  .addr_oe    (addr_oe),
  .data_oe    (data_oe),
  .burst      (burst),
  .reg_wstb   (reg_wstb),
  .xfer_valid (xfer_valid),
  .xfer_ready (xfer_ready),
  .xfer_write (xfer_write),
  .rsp_valid  (rsp_valid)
);

// File: tb/sim_host_dma_arbiter.sv
`timescale 1ns/1ps
module sim_host_dma_arbiter;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        mode_dma = 1'b0, rt_mode = 1'b0;
  logic        host_sel = 1'b0, host_rd = 1'b0, host_wr = 1'b0, host_memsel = 1'b0;
  logic [3:0]  host_idx = '0;
  logic [15:0] host_wdata = '0;
  logic        addr_off = 1'b0;
  logic [15:0] reg_rdata = 16'h1234;
  logic [13:0] reg_wstb;
  logic        dma_req, dma_gnt = 1'b0, mem_own, burst;
  logic        mem_rd, mem_wr, mem_sel;
  logic [15:0] addr_out, data_out, mem_rdata;
  logic        addr_oe, data_oe;
  logic        xfer_valid = 1'b0, xfer_ready, xfer_write = 1'b0, xfer_last = 1'b0;
  logic [15:0] xfer_addr = '0, xfer_wdata = '0;
  logic        rsp_valid;
  logic [15:0] rsp_data;

  int total = 0;
  int bad = 0;
  bit done = 0;

  always #5 clk = ~clk;

  assign mem_rdata = addr_out ^ 16'h5A5A;

  host_dma_arbiter u0 (
    .clk(clk), .rst_n(rst_n), .mode_dma(mode_dma), .rt_mode(rt_mode),
    .host_sel(host_sel), .host_rd(host_rd), .host_wr(host_wr),
    .host_memsel(host_memsel), .host_idx(host_idx), .host_wdata(host_wdata),
    .addr_off(addr_off), .reg_rdata(reg_rdata), .reg_wstb(reg_wstb),
    .dma_req(dma_req), .dma_gnt(dma_gnt), .mem_own(mem_own), .burst(burst),
    .mem_rd(mem_rd), .mem_wr(mem_wr), .mem_sel(mem_sel),
    .addr_out(addr_out), .addr_oe(addr_oe), .data_out(data_out), .data_oe(data_oe),
    .mem_rdata(mem_rdata), .xfer_valid(xfer_valid), .xfer_ready(xfer_ready),
    .xfer_write(xfer_write), .xfer_last(xfer_last), .xfer_addr(xfer_addr),
    .xfer_wdata(xfer_wdata), .rsp_valid(rsp_valid), .rsp_data(rsp_data)
  );

  task automatic chk(input string what, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", what, act, exp);
    end
  endtask

  task automatic nxt();
    @(negedge clk);
  endtask

  task automatic host_idle();
    host_sel = 0; host_rd = 0; host_wr = 0; host_memsel = 0;
  endtask

  task automatic beat(input logic wr, input logic [15:0] a, input logic [15:0] d, input logic lst);
    xfer_valid = 1; xfer_write = wr; xfer_addr = a; xfer_wdata = d; xfer_last = lst;
  endtask

  task automatic t_reset();
    #1;
    chk("R12 own in reset", mem_own, 0);
    chk("R12 req in reset", dma_req, 0);
    nxt(); rst_n = 1; nxt(); #1;
    chk("R12 own after reset", mem_own, 0);
    chk("R12 oe after reset", {addr_oe, data_oe, burst, rsp_valid, xfer_ready}, 0);
  endtask

  task automatic t_forward();
    nxt(); mode_dma = 0; host_rd = 1; host_memsel = 1; #1;
    chk("R1 read fwd", {mem_rd, mem_wr, mem_sel}, 3'b101);
    host_rd = 0; host_wr = 1; #1;
    chk("R1 write fwd", {mem_rd, mem_wr, mem_sel}, 3'b011);
    host_wr = 0; host_memsel = 0; #1;
    chk("R1 idle fwd", {mem_rd, mem_wr, mem_sel}, 3'b000);
    mode_dma = 1; host_rd = 1; host_memsel = 1; #1;
    chk("R2 no fwd in dma", {mem_rd, mem_wr, mem_sel}, 3'b000);
    host_idle(); mode_dma = 0;
  endtask

  task automatic t_decode();
    nxt(); host_sel = 1; host_wr = 1; host_idx = 5; #1;
    chk("R8 wstb idx5", reg_wstb, 14'h0020);
    host_idx = 13; #1;
    chk("R8 wstb idx13", reg_wstb, 14'h2000);
    host_idx = 14; #1;
    chk("R8 wstb idx14", reg_wstb, 0);
    host_idx = 15; #1;
    chk("R8 wstb idx15", reg_wstb, 0);
    host_wr = 0; host_rd = 1; host_idx = 2; #1;
    chk("R8 read idx2", {data_oe, data_out}, {1'b1, 16'h1234});
    host_idx = 14; #1;
    chk("R8 read idx14 zero", {data_oe, data_out}, {1'b1, 16'h0000});
    host_sel = 0; #1;
    chk("R3 no sel no drive", {addr_oe, data_oe}, 0);
    host_idle();
  endtask

  task automatic t_pt_write();
    nxt(); mode_dma = 0; beat(1, 16'h0100, 16'hBEEF, 1); #1;
    chk("R5 not yet own", {mem_own, xfer_ready}, 0);
    nxt(); #1;
    chk("R5 own pt", mem_own, 1);
    chk("R11 ready pt", xfer_ready, 1);
    chk("R2 strobes pt write", {mem_rd, mem_wr, mem_sel}, 3'b011);
    chk("R3 addr drive", {addr_oe, addr_out}, {1'b1, 16'h0100});
    chk("R3 data drive", {data_oe, data_out}, {1'b1, 16'hBEEF});
    host_sel = 1; host_wr = 1; host_idx = 5; #1;
    chk("R4 write blocked", reg_wstb, 0);
    host_wr = 0; host_rd = 1; host_idx = 2; #1;
    chk("R4 read blocked", data_out, 16'hBEEF);
    host_idle();
    nxt(); xfer_valid = 0; #1;
    chk("R5 own released", mem_own, 0);
    chk("R3 released", {addr_oe, data_oe}, 0);
  endtask

  task automatic t_pt_read();
    nxt(); beat(0, 16'h0042, 16'h0, 1);
    nxt(); #1;
    chk("R11 read strobe", {mem_rd, mem_wr, mem_sel, data_oe}, 4'b1010);
    chk("R11 no rsp yet", rsp_valid, 0);
    nxt(); xfer_valid = 0; #1;
    chk("R11 rsp pulse", {rsp_valid, rsp_data}, {1'b1, 16'h5A18});
    nxt(); #1;
    chk("R11 rsp one cycle", rsp_valid, 0);
  endtask

  task automatic t_dma_burst();
    nxt(); mode_dma = 1; dma_gnt = 0; beat(1, 16'h0200, 16'h1111, 0);
    nxt(); #1;
    chk("R10 req raised", {dma_req, mem_own, xfer_ready}, 3'b100);
    chk("R2 no strobe before grant", {mem_rd, mem_wr, mem_sel}, 0);
    nxt(); #1;
    chk("R10 req waits", {dma_req, mem_own}, 2'b10);
    dma_gnt = 1;
    nxt(); #1;
    chk("R5 own after grant", {mem_own, xfer_ready, mem_wr}, 3'b111);
    chk("R7 burst first beat", burst, 1);
    addr_off = 1; #1;
    chk("R6 addr off", addr_oe, 0);
    addr_off = 0; #1;
    chk("R6 addr back", addr_oe, 1);
    nxt(); beat(1, 16'h0201, 16'h2222, 0); #1;
    chk("R7 burst mid", burst, 1);
    nxt(); beat(1, 16'h0202, 16'h3333, 1); #1;
    chk("R7 burst last beat", {burst, mem_own, dma_req}, 3'b111);
    nxt(); beat(1, 16'h0300, 16'h4444, 1); #1;
    chk("R10 req dropped", {dma_req, mem_own, xfer_ready}, 0);
    chk("R7 burst off", burst, 0);
    nxt(); #1;
    chk("R10 no req while grant held", dma_req, 0);
    dma_gnt = 0;
    nxt(); #1;
    chk("R10 idle after grant fall", dma_req, 0);
    nxt(); #1;
    chk("R10 new req", dma_req, 1);
    dma_gnt = 1;
    nxt(); #1;
    chk("R7 single beat no burst", {mem_own, burst}, 2'b10);
    nxt(); xfer_valid = 0; dma_gnt = 0;
    nxt(); #1;
    chk("R10 back to idle", {dma_req, mem_own}, 0);
  endtask

  task automatic t_busy();
    nxt(); mode_dma = 1; rt_mode = 1;
    host_sel = 1; host_wr = 1; host_idx = 3; host_wdata = 16'h8000; #1;
    chk("R9 busy write strobe", reg_wstb, 14'h0008);
    nxt(); host_idle(); beat(0, 16'h0010, 16'h0, 1);
    for (int i = 0; i < 3; i++) begin
      nxt(); #1;
      chk("R9 busy inhibits", {dma_req, mem_own}, 0);
    end
    rt_mode = 0;
    nxt(); #1;
    chk("R9 busy ignored off rt", dma_req, 1);
    dma_gnt = 1;
    nxt(); #1;
    chk("R9 own after grant", mem_own, 1);
    nxt(); xfer_valid = 0; dma_gnt = 0;
    nxt(); host_sel = 1; host_wr = 1; host_idx = 3; host_wdata = 16'h0000;
    nxt(); host_idle(); rt_mode = 1; beat(0, 16'h0011, 16'h0, 1);
    nxt(); #1;
    chk("R9 busy cleared", dma_req, 1);
    dma_gnt = 1;
    nxt(); nxt(); xfer_valid = 0; dma_gnt = 0; rt_mode = 0;
    nxt(); nxt();
  endtask

  task automatic t_reset_mid();
    nxt(); mode_dma = 0; beat(1, 16'h0500, 16'h5555, 0);
    nxt(); #1;
    chk("R12 own before reset", mem_own, 1);
    rst_n = 0; #1;
    chk("R12 async own drop", {mem_own, dma_req, burst}, 0);
    chk("R12 async bus release", {addr_oe, data_oe, rsp_valid}, 0);
    xfer_valid = 0;
    nxt(); rst_n = 1;
    nxt(); #1;
    chk("R12 idle after reset", {mem_own, xfer_ready}, 0);
  endtask

  initial begin
    t_reset();
    t_forward();
    t_decode();
    t_pt_write();
    t_pt_read();
    t_dma_burst();
    t_busy();
    t_reset_mid();
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog act=hung exp=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule